// File: doc/BRIEF.md
# Partitioned SRAM-Emulated TCAM Layer

This block is one layer of a ternary lookup table. It uses small directly addressed tables in place of a match line and a comparator per entry. A search key of `NSUB * SUBW` bits is cut into `NSUB` slices of `SUBW` bits, and subword `i` is `key[i*SUBW +: SUBW]`. Each slice has its own bank of three tables. The first is a presence table of `2^SUBW` x 1 bit. The second is a pointer table of `2^SUBW` x `SUBW` bits. The third is a row table of `2^SUBW` x `KADDR` bits, where bit `a` of a row stands for rule address `a` of this layer. During a search, each slice reads its presence bit and its pointer in the first pipeline stage. In the second stage it reads the row that the pointer selects. The rows of all slices are ANDed, the result is masked with the AND of all presence bits, and a priority encoder turns the set into one potential match address and a hit flag.

Rules are written one at a time through a programming port as a value plus a care mask, where a care bit of 0 means "don't care". The sequencer walks every possible subword value over `2^SUBW` cycles, so every concrete subword covered by the rule's don't-care bits gets written. The first time a slice sees a subword value, it gives that value the next free row of its row table and stores the row number in the pointer table. Later rules that reuse the value only set further bits in that same row. A one-cycle clear command zeroes every table. Choosing between layers is left to logic outside this block.

Top module: `ztl_layer`

## Requirements
- R1: After reset or after `clr`, every search reports `res_hit`=0, including a search for a rule whose programming was cut short by `clr`. `res_hit` is 0 whenever `res_valid` is 0.
- R2: A search strobed at a clock edge produces `res_valid` exactly two edges later, and never at any other time. Searches on consecutive cycles give results on consecutive cycles, in order.
- R3: A key equal to a programmed rule value, with all care bits set to 1, reports `res_hit`=1 and `res_pma` equal to that rule's address.
- R4: A care bit of 0 matches both values of that key bit. For example, value 0100 with care 1110 matches keys 0100 and 0101 and no other key.
- R5: If any subword of the key was never written into its slice's presence table, the result is a miss.
- R6: If every subword is present but no single rule address is set in all of the selected rows, the result is a miss. For example, with rule 0011 at address 0 and rule 0101 at address 1, key 0001 misses.
- R7: When several rule addresses match, `res_pma` is the lowest of them.
- R8: A programming request is accepted only when `prog_busy`=0, `srch_valid`=0 and `clr`=0. `prog_busy` is then high for exactly `2^SUBW` cycles, and any `prog_valid` seen while busy is ignored.
- R9: With rule 0011 at address 0 and rule 0101 at address 1, key 0011 reports a hit at address 0.
- R10: On a miss, `res_pma` is 0.
- R11: `clr` ends any programming in progress, so `prog_busy` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear all tables and abort programming |
| prog_valid | input | 1 | Programming request |
| prog_addr | input | AW | Rule address within the layer |
| prog_value | input | NSUB*SUBW | Rule value |
| prog_care | input | NSUB*SUBW | Care mask (1 = bit must match) |
| prog_busy | output | 1 | Expansion of a rule in progress |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | NSUB*SUBW | Search key |
| res_valid | output | 1 | Search result valid |
| res_hit | output | 1 | Potential match found |
| res_pma | output | AW | Potential match address (lowest matching rule) |

## Verification
The bound checker watches, on every cycle, the two-cycle spacing between a search strobe and its result, the gating of the hit flag and the zero address on a miss. It also checks that no hit appears while the tables are known to be empty, that programming is accepted and lasts exactly `2^SUBW` cycles, and that a clear drops the busy flag. Whether a hit is correct and which address it reports depend on the full contents of the tables, so only the bench's scenarios can show them. Those scenarios cover exact rules, don't-care expansion, an absent subword, present subwords whose rows do not intersect, lowest-address priority, a request ignored while busy, and a clear in the middle of programming. The bench compares every result against its own model of which subword values each address covers.

// File: rtl/ztl_pkg.sv
// Package: shared helpers and types for the partitioned TCAM layer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package ztl_pkg;

    // Index width for n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Programming sequencer state.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_EXPAND = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ztl_prog_seq.sv
// Module: ztl_prog_seq
// Latches one ternary rule and sweeps a candidate subword value through
// 0 .. 2^SUBW-1, one value per cycle. Every slice tests the same candidate
// against its own part of the rule. Assumes the caller keeps searches off
// while busy; a request is taken only when no search strobe is present.
module ztl_prog_seq #(
    parameter int NSUB  = 2,
    parameter int SUBW  = 2,
    parameter int AW    = 1,
    localparam int KEYW = NSUB * SUBW,
    localparam int DEPTH = 1 << SUBW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            prog_valid,
    input  logic [AW-1:0]   prog_addr,
    input  logic [KEYW-1:0] prog_value,
    input  logic [KEYW-1:0] prog_care,
    input  logic            srch_valid,
    output logic            busy,
    output logic            wr_en,
    output logic [SUBW-1:0] wr_cand,
    output logic [KEYW-1:0] rule_val,
    output logic [KEYW-1:0] rule_care,
    output logic [AW-1:0]   rule_addr
);
    import ztl_pkg::*;

    seq_state_e    state_q;
    logic [SUBW-1:0] cnt_q;

    // Accept a rule when idle, then step the candidate until the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            cnt_q     <= '0;
            rule_val  <= '0;
            rule_care <= '0;
            rule_addr <= '0;
        end else if (clr) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (prog_valid && !srch_valid) begin
                        state_q   <= SEQ_EXPAND;
                        cnt_q     <= '0;
                        rule_val  <= prog_value;
                        rule_care <= prog_care;
                        rule_addr <= prog_addr;
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == SUBW'(DEPTH - 1)) begin
                        state_q <= SEQ_IDLE;
                    end
                end
            endcase
        end
    end

    // Outputs follow the state directly.
    assign busy    = (state_q == SEQ_EXPAND);
    assign wr_en   = busy;
    assign wr_cand = cnt_q;

endmodule

// File: rtl/ztl_subtable.sv
// Module: ztl_subtable
// Storage for one key slice: presence bits, row pointers and address-bit
// rows, each 2^SUBW deep. Rows are handed out in order of first use, so
// the row table never overflows: there are at most 2^SUBW distinct values.
// Reads are combinational; the caller registers them.
module ztl_subtable #(
    parameter int SUBW  = 2,
    parameter int KADDR = 2,
    parameter int AW    = 1,
    localparam int DEPTH = 1 << SUBW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [SUBW-1:0]  wr_cand,
    input  logic [SUBW-1:0]  wr_val,
    input  logic [SUBW-1:0]  wr_care,
    input  logic [AW-1:0]    wr_addr,
    input  logic [SUBW-1:0]  rd_sub,
    output logic             rd_present,
    output logic [SUBW-1:0]  rd_ptr,
    input  logic [SUBW-1:0]  row_sel,
    output logic [KADDR-1:0] row_bits
);
    logic             pres_q [DEPTH];
    logic [SUBW-1:0]  ptr_q  [DEPTH];
    logic [KADDR-1:0] row_q  [DEPTH];
    logic [SUBW-1:0]  alloc_q;
    logic             cand_hit;

    // The candidate is covered by the rule slice when all cared bits agree.
    assign cand_hit = wr_en && (((wr_cand ^ wr_val) & wr_care) == '0);

    // Clear on reset or command; otherwise record a covered candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            alloc_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pres_q[i] <= 1'b0;
                ptr_q[i]  <= '0;
                row_q[i]  <= '0;
            end
        end else if (cand_hit) begin
            if (!pres_q[wr_cand]) begin
                pres_q[wr_cand]         <= 1'b1;
                ptr_q[wr_cand]          <= alloc_q;
                row_q[alloc_q][wr_addr] <= 1'b1;
                alloc_q                 <= alloc_q + 1'b1;
            end else begin
                row_q[ptr_q[wr_cand]][wr_addr] <= 1'b1;
            end
        end
    end

    // Combinational read ports.
    assign rd_present = pres_q[rd_sub];
    assign rd_ptr     = ptr_q[rd_sub];
    assign row_bits   = row_q[row_sel];

endmodule

// File: rtl/ztl_lpe.sv
// Module: ztl_lpe
// Layer priority encoder: the lowest set bit wins. With no bit set, hit is
// 0 and the index is 0.
module ztl_lpe #(
    parameter int KADDR = 2,
    parameter int AW    = 1
) (
    input  logic [KADDR-1:0] vec,
    output logic             hit,
    output logic [AW-1:0]    idx
);
    // Scan from the top down so the lowest set bit is assigned last.
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int k = KADDR - 1; k >= 0; k--) begin
            if (vec[k]) idx = AW'(k);
        end
    end
endmodule

// File: rtl/ztl_layer.sv
// Module: ztl_layer (top)
// One layer of the SRAM-emulated TCAM. Stage 1 reads presence bits and
// pointers for every slice. Stage 2 reads the selected rows, ANDs them,
// masks the result with the AND of the presence bits and priority-encodes
// it. Assumes searches are kept off while prog_busy is high.
module ztl_layer #(
    parameter int NSUB  = 2,
    parameter int SUBW  = 2,
    parameter int KADDR = 2,
    localparam int KEYW = NSUB * SUBW,
    localparam int AW   = ztl_pkg::idx_w(KADDR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            prog_valid,
    input  logic [AW-1:0]   prog_addr,
    input  logic [KEYW-1:0] prog_value,
    input  logic [KEYW-1:0] prog_care,
    output logic            prog_busy,
    input  logic            srch_valid,
    input  logic [KEYW-1:0] srch_key,
    output logic            res_valid,
    output logic            res_hit,
    output logic [AW-1:0]   res_pma
);
    logic             wr_en;
    logic [SUBW-1:0]  wr_cand;
    logic [KEYW-1:0]  rule_val;
    logic [KEYW-1:0]  rule_care;
    logic [AW-1:0]    rule_addr;

    logic [NSUB-1:0]  rd_present;
    logic [SUBW-1:0]  rd_ptr [NSUB];
    logic [KADDR-1:0] rows   [NSUB];

    logic             s1_valid;
    logic             s1_allp;
    logic [SUBW-1:0]  s1_ptr [NSUB];

    logic [KADDR-1:0] match_vec;
    logic             lpe_hit;
    logic [AW-1:0]    lpe_idx;

    ztl_prog_seq #(.NSUB(NSUB), .SUBW(SUBW), .AW(AW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .prog_valid(prog_valid),
        .prog_addr (prog_addr),
        .prog_value(prog_value),
        .prog_care (prog_care),
        .srch_valid(srch_valid),
        .busy      (prog_busy),
        .wr_en     (wr_en),
        .wr_cand   (wr_cand),
        .rule_val  (rule_val),
        .rule_care (rule_care),
        .rule_addr (rule_addr)
    );

    // One storage bank per key slice.
    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        ztl_subtable #(.SUBW(SUBW), .KADDR(KADDR), .AW(AW)) tbl_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .wr_en     (wr_en),
            .wr_cand   (wr_cand),
            .wr_val    (rule_val[i*SUBW +: SUBW]),
            .wr_care   (rule_care[i*SUBW +: SUBW]),
            .wr_addr   (rule_addr),
            .rd_sub    (srch_key[i*SUBW +: SUBW]),
            .rd_present(rd_present[i]),
            .rd_ptr    (rd_ptr[i]),
            .row_sel   (s1_ptr[i]),
            .row_bits  (rows[i])
        );
    end

    // Stage 1: register the presence AND and the row pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_allp  <= 1'b0;
            for (int i = 0; i < NSUB; i++) s1_ptr[i] <= '0;
        end else begin
            s1_valid <= srch_valid;
            s1_allp  <= &rd_present;
            for (int i = 0; i < NSUB; i++) s1_ptr[i] <= rd_ptr[i];
        end
    end

    // AND the rows of all slices, then gate the result with presence.
    always_comb begin
        match_vec = '1;
        for (int i = 0; i < NSUB; i++) match_vec = match_vec & rows[i];
        match_vec = match_vec & {KADDR{s1_allp}};
    end

    ztl_lpe #(.KADDR(KADDR), .AW(AW)) lpe_i (
        .vec(match_vec),
        .hit(lpe_hit),
        .idx(lpe_idx)
    );

    // Stage 2: register the encoded result; the address is zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_pma   <= '0;
        end else begin
            res_valid <= s1_valid;
            res_hit   <= s1_valid && lpe_hit;
            res_pma   <= (s1_valid && lpe_hit) ? lpe_idx : '0;
        end
    end

endmodule

// File: rtl/ztl_layer_chk.sv
// Module: ztl_layer_chk
// Protocol and timing checker bound to ztl_layer. It watches only ports
// and keeps its own history registers for the windows it needs.
module ztl_layer_chk #(
    parameter int SUBW  = 2,
    parameter int KADDR = 2,
    localparam int AW    = ztl_pkg::idx_w(KADDR),
    localparam int DEPTH = 1 << SUBW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          prog_valid,
    input logic          prog_busy,
    input logic          srch_valid,
    input logic          res_valid,
    input logic          res_hit,
    input logic [AW-1:0] res_pma
);
    logic          empty_q;
    logic [2:0]    empty_hist;
    logic [SUBW:0] busy_cnt;
    logic          accept;

    assign accept = prog_valid && !prog_busy && !srch_valid && !clr;

    // Track whether the tables are known to be empty, with a short history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q    <= 1'b1;
            empty_hist <= 3'b111;
        end else begin
            if (clr)         empty_q <= 1'b1;
            else if (accept) empty_q <= 1'b0;
            empty_hist <= {empty_hist[1:0], empty_q};
        end
    end

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_cnt <= '0;
        else if (prog_busy) busy_cnt <= busy_cnt + 1'b1;
        else                busy_cnt <= '0;
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |-> ##2 res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(srch_valid, 2));
    a_r1_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_hit);
    a_r1_empty_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && empty_q && (&empty_hist)) |-> !res_hit);
    a_r10_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_pma == '0));
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> prog_busy);
    a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (busy_cnt < (SUBW+1)'(DEPTH)));
    a_r8_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_busy) && !$past(clr)) |-> (busy_cnt == (SUBW+1)'(DEPTH)));
    a_r11_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !prog_busy);

endmodule

bind ztl_layer ztl_layer_chk #(.SUBW(SUBW), .KADDR(KADDR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .prog_valid(prog_valid),
    .prog_busy (prog_busy),
    .srch_valid(srch_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_pma   (res_pma)
);

// File: tb/ztl_layer_tb_top.sv
// Scoreboard bench for ztl_layer: the search task pushes expected results
// from a bench-side coverage model; a monitor pops and compares them.
module ztl_layer_tb_top;
    localparam int NSUB  = 2;
    localparam int SUBW  = 2;
    localparam int KADDR = 2;
    localparam int KEYW  = NSUB * SUBW;
    localparam int AW    = 1;
    localparam int DEPTH = 1 << SUBW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            prog_valid = 1'b0;
    logic [AW-1:0]   prog_addr = '0;
    logic [KEYW-1:0] prog_value = '0;
    logic [KEYW-1:0] prog_care = '0;
    logic            prog_busy;
    logic            srch_valid = 1'b0;
    logic [KEYW-1:0] srch_key = '0;
    logic            res_valid;
    logic            res_hit;
    logic [AW-1:0]   res_pma;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    hit;
        int    pma;
        int    due;
        string req;
    } exp_t;
    exp_t sb_q[$];

    // Coverage model: which subword values each rule address covers per slice.
    bit mdl [KADDR][NSUB][DEPTH];

    ztl_layer #(.NSUB(NSUB), .SUBW(SUBW), .KADDR(KADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .prog_valid(prog_valid), .prog_addr(prog_addr),
        .prog_value(prog_value), .prog_care(prog_care),
        .prog_busy(prog_busy),
        .srch_valid(srch_valid), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_pma(res_pma)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int a = 0; a < KADDR; a++)
            for (int i = 0; i < NSUB; i++)
                for (int v = 0; v < DEPTH; v++) mdl[a][i][v] = 1'b0;
    endtask

    task automatic mdl_add(input int a, input logic [KEYW-1:0] val,
                           input logic [KEYW-1:0] care);
        for (int i = 0; i < NSUB; i++)
            for (int v = 0; v < DEPTH; v++)
                if (((SUBW'(v) ^ val[i*SUBW +: SUBW]) & care[i*SUBW +: SUBW]) == '0)
                    mdl[a][i][v] = 1'b1;
    endtask

    // Starts a rule; optionally offers a second rule while busy (must be ignored).
    task automatic do_prog(input int a, input logic [KEYW-1:0] val,
                           input logic [KEYW-1:0] care, input bit inject,
                           input int a2, input logic [KEYW-1:0] val2);
        int n;
        @(negedge clk);
        prog_valid = 1'b1; prog_addr = AW'(a); prog_value = val; prog_care = care;
        @(negedge clk);
        prog_valid = 1'b0;
        check(prog_busy == 1'b1, "R8", "busy after request", prog_busy, 1);
        mdl_add(a, val, care);
        n = 0;
        while (prog_busy) begin
            n++;
            if (inject && n == 1) begin
                prog_valid = 1'b1; prog_addr = AW'(a2);
                prog_value = val2; prog_care = '1;
            end else begin
                prog_valid = 1'b0;
            end
            @(negedge clk);
        end
        prog_valid = 1'b0;
        check(n == DEPTH, "R8", "busy length", n, DEPTH);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        mdl_clear();
        check(prog_busy == 1'b0, "R11", "busy after clear", prog_busy, 0);
    endtask

    // Drives a search strobe for the next cycle and queues its expected result.
    task automatic issue(input logic [KEYW-1:0] key, input string req);
        exp_t e;
        bit ok;
        @(negedge clk);
        srch_valid = 1'b1; srch_key = key;
        e.hit = 0; e.pma = 0; e.req = req; e.due = cyc + 2;
        for (int a = 0; a < KADDR; a++) begin
            ok = 1'b1;
            for (int i = 0; i < NSUB; i++)
                if (!mdl[a][i][key[i*SUBW +: SUBW]]) ok = 1'b0;
            if (ok && e.hit == 0) begin e.hit = 1; e.pma = a; end
        end
        sb_q.push_back(e);
    endtask

    task automatic settle(input int n);
        @(negedge clk); srch_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cyc == e.due, "R2", "result cycle", cyc, e.due);
                check(int'(res_hit) == e.hit, e.req, "hit", res_hit, e.hit);
                check(int'(res_pma) == e.pma, e.req, "pma", res_pma, e.pma);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        mdl_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(prog_busy == 1'b0, "R1", "busy after reset", prog_busy, 0);
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(res_hit == 1'b0, "R1", "res_hit after reset", res_hit, 0);
        issue(4'b0000, "R1");
        issue(4'b0011, "R1");
        settle(3);

        // R9 / R3 / R5 / R6: the reference pair of rules
        do_prog(0, 4'b0011, 4'b1111, 1'b0, 0, '0);
        do_prog(1, 4'b0101, 4'b1111, 1'b0, 0, '0);
        issue(4'b0011, "R9");
        issue(4'b0101, "R3");
        issue(4'b0001, "R6");
        issue(4'b1011, "R5");
        issue(4'b0111, "R6");
        settle(3);

        // R1: clear empties the tables
        do_clear();
        issue(4'b0011, "R1");
        issue(4'b0101, "R1");
        settle(3);

        // R4: don't-care expansion, one and two free bits
        do_prog(1, 4'b0100, 4'b1110, 1'b0, 0, '0);
        do_prog(0, 4'b0011, 4'b0011, 1'b0, 0, '0);
        issue(4'b0100, "R4");
        issue(4'b0101, "R4");
        issue(4'b0110, "R4");
        issue(4'b0111, "R4");
        issue(4'b1111, "R4");
        issue(4'b1101, "R10");
        settle(3);

        // R7: overlapping rules, lowest address wins
        do_clear();
        do_prog(1, 4'b0000, 4'b1100, 1'b0, 0, '0);
        do_prog(0, 4'b0000, 4'b1010, 1'b0, 0, '0);
        issue(4'b0000, "R7");
        issue(4'b0001, "R7");
        issue(4'b0010, "R7");
        issue(4'b0101, "R7");
        issue(4'b1000, "R10");
        settle(3);

        // R8: a request offered while busy is ignored
        do_clear();
        do_prog(0, 4'b1100, 4'b1111, 1'b1, 1, 4'b1010);
        issue(4'b1100, "R8");
        issue(4'b1010, "R8");
        settle(3);

        // R11: clear in the middle of programming
        do_clear();
        @(negedge clk);
        prog_valid = 1'b1; prog_addr = '0; prog_value = 4'b1111; prog_care = 4'b1111;
        @(negedge clk);
        prog_valid = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(prog_busy == 1'b0, "R11", "busy after mid-program clear", prog_busy, 0);
        issue(4'b1111, "R1");
        settle(4);

        check(sb_q.size() == 0, "R2", "results outstanding", sb_q.size(), 0);
        finish_run();
    end
endmodule